// File: doc/BRIEF.md
# Static Branch Direction and Target Predictor

This unit sits in the decode stage. It looks at each decoded instruction word together with the PC that fetched it and decides whether the word is a conditional branch. For a branch it forms the predicted target by sign-extending the displacement field, scaling it to a word offset and adding it to the PC. It then predicts the direction under one of three static policies chosen by a mode input. When the prediction is taken, the unit raises a one-cycle fetch-redirect pulse. Because the target only exists after decode, every redirect costs fetch slots, and the unit signals them on a bubble output.

The unit does not resolve branches. A resolve port reports the actual outcome of each recorded prediction, oldest first. The unit uses these outcomes only to keep saturating accuracy counters, with backward and forward branches counted separately. Outstanding predictions wait in a small in-order tracker until their outcome arrives.

Top module: `brp_static_top`

## Requirements
- R1: Synchronous active-high reset clears every output to zero, including all four accuracy counters, and empties the prediction tracker.
- R2: A word is a branch when `in_valid_i` is high and bits [31:26] equal the `BR_OPCODE` parameter (default 6'b000100). `out_valid_o` and `is_branch_o` show this one cycle after the input is presented.
- R3: The target is the input PC plus the sign-extended bits [15:0] shifted left by two, computed modulo 2^32. It appears on `target_o` in the same cycle as `is_branch_o`.
- R4: With `mode_i` = 2'b00, no branch is predicted taken and no redirect is raised.
- R5: With `mode_i` = 2'b01, every detected branch is predicted taken.
- R6: With `mode_i` = 2'b10 or 2'b11, a branch whose displacement sign bit (bit 15) is 1 is predicted taken, and a branch with a zero or positive displacement is predicted not taken.
- R7: An invalid word or a non-branch word never raises `is_branch_o`, `pred_taken_o` or `redirect_o`.
- R8: `redirect_o` is high for exactly the cycle that follows an input predicted taken. `bubble_o` is high for `BUBBLES` consecutive cycles starting with that redirect cycle, and a newer redirect restarts the count.
- R9: Each detected branch is recorded with its class (backward when bit 15 is 1) and its predicted direction, unless `TRACK_DEPTH` entries are already outstanding and no resolve arrives in the same cycle. Each `resolve_valid_i` retires the oldest record. It increments the prediction counter of that record's class, and it also increments the class's correct counter when `resolve_taken_i` equals the predicted direction. Counter updates are visible one cycle later.
- R10: All four counters saturate at 16'hFFFF.
- R11: A resolve that arrives while no prediction is outstanding leaves all counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy: 00 never taken, 01 always taken, 1x backward taken |
| in_valid_i | input | 1 | Decoded word valid |
| in_insn_i | input | 32 | Decoded instruction word |
| in_pc_i | input | 32 | PC of the word |
| resolve_valid_i | input | 1 | Outcome of the oldest outstanding prediction is present |
| resolve_taken_i | input | 1 | Actual direction of that branch |
| out_valid_o | output | 1 | Registered copy of the input valid |
| is_branch_o | output | 1 | Word was a conditional branch |
| pred_taken_o | output | 1 | Predicted direction |
| target_o | output | 32 | Predicted target address |
| redirect_o | output | 1 | One-cycle fetch redirect |
| bubble_o | output | 1 | Fetch slot lost to a redirect |
| bwd_pred_cnt_o | output | 16 | Resolved backward predictions |
| bwd_hit_cnt_o | output | 16 | Correct backward predictions |
| fwd_pred_cnt_o | output | 16 | Resolved forward predictions |
| fwd_hit_cnt_o | output | 16 | Correct forward predictions |

## Verification
The checker assumes that `mode_i` changes only between instructions, that reset is held for at least two cycles before the first property is evaluated, and that resolves refer to predictions in the order they were made. The stimulus applies reset for several cycles, changes the mode only between groups of words, and issues resolves in order to a reference queue. It deliberately overruns the tracker and issues resolves while nothing is outstanding, so that dropped records and ignored resolves are visible in the counters.

// File: rtl/brp_pkg.sv
package brp_pkg;

    localparam int XLEN   = 32;
    localparam int OFF_W  = 16;
    localparam int OPC_W  = 6;
    localparam int OPC_LO = XLEN - OPC_W;
    localparam int SCALE  = 2;
    localparam int EXT_W  = XLEN - OFF_W - SCALE;

    typedef enum logic [1:0] {
        POL_NEVER    = 2'b00,
        POL_ALWAYS   = 2'b01,
        POL_BACKWARD = 2'b10,
        POL_BACK_ALT = 2'b11
    } policy_e;

    typedef struct packed {
        logic            is_branch;
        logic            backward;
        logic [XLEN-1:0] target;
    } br_fields_t;

    typedef struct packed {
        logic backward;
        logic pred_taken;
    } track_t;

    typedef enum logic {
        CLS_FWD = 1'b0,
        CLS_BWD = 1'b1
    } br_class_e;

    function automatic logic [XLEN-1:0] disp_to_offset(input logic [OFF_W-1:0] disp);
        return {{EXT_W{disp[OFF_W-1]}}, disp, {SCALE{1'b0}}};
    endfunction

    function automatic logic [XLEN-1:0] form_target(input logic [XLEN-1:0] pc,
                                                    input logic [OFF_W-1:0] disp);
        return pc + disp_to_offset(disp);
    endfunction

endpackage

// File: rtl/brp_decode.sv
module brp_decode
    import brp_pkg::*;
#(
    parameter logic [OPC_W-1:0] BR_OPCODE = 6'b000100
) (
    input  logic            valid_i,
    input  logic [XLEN-1:0] insn_i,
    input  logic [XLEN-1:0] pc_i,
    output br_fields_t      fields_o
);
    logic [OPC_W-1:0] opc;
    logic [OFF_W-1:0] disp;

    always_comb begin
        opc                = insn_i[XLEN-1:OPC_LO];
        disp               = insn_i[OFF_W-1:0];
        fields_o.is_branch = valid_i && (opc == BR_OPCODE);
        fields_o.backward  = disp[OFF_W-1];
        fields_o.target    = form_target(pc_i, disp);
    end
endmodule

// File: rtl/brp_policy.sv
module brp_policy
    import brp_pkg::*;
(
    input  logic [1:0] mode_i,
    input  br_fields_t fields_i,
    output logic       taken_o
);
    policy_e pol;
    logic    dir;

    always_comb begin
        pol = policy_e'(mode_i);
        unique case (pol)
            POL_NEVER:    dir = 1'b0;
            POL_ALWAYS:   dir = 1'b1;
            POL_BACKWARD,
            POL_BACK_ALT: dir = fields_i.backward;
            default:      dir = 1'b0;
        endcase
        taken_o = fields_i.is_branch && dir;
    end
endmodule

// File: rtl/brp_bubble.sv
module brp_bubble #(
    parameter int BUBBLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic bubble_o
);
    localparam int CW = (BUBBLES < 2) ? 1 : $clog2(BUBBLES + 1);
    localparam logic [CW-1:0] LOADV = CW'(BUBBLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load_i) begin
            remain <= LOADV;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign bubble_o = (remain != '0);
endmodule

// File: rtl/brp_tracker.sv
module brp_tracker
    import brp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  track_t push_data_i,
    input  logic   pop_i,
    output logic   head_valid_o,
    output track_t head_o
);
    localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    track_t        slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] level;
    logic          do_pop;
    logic          do_push;

    always_comb begin
        head_valid_o = (level != '0);
        do_pop       = pop_i && head_valid_o;
        do_push      = push_i && ((level != FULLV) || do_pop);
        head_o       = slots[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (do_push && (wr_ptr == PW'(g))) begin
                slots[g] <= push_data_i;
            end
        end
    end
endmodule

// File: rtl/brp_stats.sv
module brp_stats
    import brp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic             upd_backward_i,
    input  logic             upd_correct_i,
    output logic [CNT_W-1:0] pred_cnt_o [2],
    output logic [CNT_W-1:0] hit_cnt_o  [2]
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    for (genvar c = 0; c < 2; c++) begin : g_cls
        logic sel;
        assign sel = upd_i && (br_class_e'(upd_backward_i) == br_class_e'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                pred_cnt_o[c] <= '0;
                hit_cnt_o[c]  <= '0;
            end else if (sel) begin
                if (pred_cnt_o[c] != MAXV) begin
                    pred_cnt_o[c] <= pred_cnt_o[c] + 1'b1;
                end
                if (upd_correct_i && (hit_cnt_o[c] != MAXV)) begin
                    hit_cnt_o[c] <= hit_cnt_o[c] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/brp_static_top.sv
module brp_static_top
    import brp_pkg::*;
#(
    parameter logic [5:0] BR_OPCODE   = 6'b000100,
    parameter int         BUBBLES     = 1,
    parameter int         TRACK_DEPTH = 4,
    parameter int         CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             in_valid_i,
    input  logic [31:0]      in_insn_i,
    input  logic [31:0]      in_pc_i,
    input  logic             resolve_valid_i,
    input  logic             resolve_taken_i,
    output logic             out_valid_o,
    output logic             is_branch_o,
    output logic             pred_taken_o,
    output logic [31:0]      target_o,
    output logic             redirect_o,
    output logic             bubble_o,
    output logic [CNT_W-1:0] bwd_pred_cnt_o,
    output logic [CNT_W-1:0] bwd_hit_cnt_o,
    output logic [CNT_W-1:0] fwd_pred_cnt_o,
    output logic [CNT_W-1:0] fwd_hit_cnt_o
);
    br_fields_t       fields;
    logic             taken;
    track_t           rec;
    track_t           head;
    logic             head_valid;
    logic             retire;
    logic [CNT_W-1:0] pred_cnt [2];
    logic [CNT_W-1:0] hit_cnt  [2];

    brp_decode #(.BR_OPCODE(BR_OPCODE)) u_decode (
        .valid_i  (in_valid_i),
        .insn_i   (in_insn_i),
        .pc_i     (in_pc_i),
        .fields_o (fields)
    );

    brp_policy u_policy (
        .mode_i   (mode_i),
        .fields_i (fields),
        .taken_o  (taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o  <= 1'b0;
            is_branch_o  <= 1'b0;
            pred_taken_o <= 1'b0;
            redirect_o   <= 1'b0;
            target_o     <= '0;
        end else begin
            out_valid_o  <= in_valid_i;
            is_branch_o  <= fields.is_branch;
            pred_taken_o <= taken;
            redirect_o   <= taken;
            if (in_valid_i) begin
                target_o <= fields.target;
            end
        end
    end

    brp_bubble #(.BUBBLES(BUBBLES)) u_bubble (
        .clk      (clk),
        .rst      (rst),
        .load_i   (taken),
        .bubble_o (bubble_o)
    );

    always_comb begin
        rec.backward   = fields.backward;
        rec.pred_taken = taken;
        retire         = resolve_valid_i && head_valid;
    end

    brp_tracker #(.DEPTH(TRACK_DEPTH)) u_tracker (
        .clk          (clk),
        .rst          (rst),
        .push_i       (fields.is_branch),
        .push_data_i  (rec),
        .pop_i        (resolve_valid_i),
        .head_valid_o (head_valid),
        .head_o       (head)
    );

    brp_stats #(.CNT_W(CNT_W)) u_stats (
        .clk            (clk),
        .rst            (rst),
        .upd_i          (retire),
        .upd_backward_i (head.backward),
        .upd_correct_i  (head.pred_taken == resolve_taken_i),
        .pred_cnt_o     (pred_cnt),
        .hit_cnt_o      (hit_cnt)
    );

    assign bwd_pred_cnt_o = pred_cnt[CLS_BWD];
    assign bwd_hit_cnt_o  = hit_cnt[CLS_BWD];
    assign fwd_pred_cnt_o = pred_cnt[CLS_FWD];
    assign fwd_hit_cnt_o  = hit_cnt[CLS_FWD];
endmodule

// File: rtl/brp_chk.sv
module brp_chk #(
    parameter logic [5:0] BR_OPCODE = 6'b000100,
    parameter int         CNT_W     = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic             in_valid_i,
    input logic [31:0]      in_insn_i,
    input logic             out_valid_o,
    input logic             is_branch_o,
    input logic             pred_taken_o,
    input logic             redirect_o,
    input logic             bubble_o,
    input logic [CNT_W-1:0] bwd_pred_cnt_o,
    input logic [CNT_W-1:0] bwd_hit_cnt_o,
    input logic [CNT_W-1:0] fwd_pred_cnt_o,
    input logic [CNT_W-1:0] fwd_hit_cnt_o
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);

    // R7
    redirect_needs_branch_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (is_branch_o && pred_taken_o && out_valid_o));

    // R7
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> (!is_branch_o && !redirect_o));

    // R4
    never_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i == 2'b00) |=> (!pred_taken_o && !redirect_o));

    // R5
    always_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i == 2'b01 && in_insn_i[31:26] == BR_OPCODE) |=> redirect_o);

    // R6
    fwd_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i[1] && !in_insn_i[15]) |=> !pred_taken_o);

    // R8
    redirect_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> bubble_o);

    // R9
    bwd_hit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bwd_hit_cnt_o <= bwd_pred_cnt_o);

    // R9
    fwd_hit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_hit_cnt_o <= fwd_pred_cnt_o);

    // R10
    fwd_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fwd_pred_cnt_o == $past(fwd_pred_cnt_o) ||
                  fwd_pred_cnt_o == $past(fwd_pred_cnt_o) + 1'b1));

    // R10
    bwd_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bwd_pred_cnt_o == $past(bwd_pred_cnt_o) ||
                  bwd_pred_cnt_o == $past(bwd_pred_cnt_o) + 1'b1));
endmodule

bind brp_static_top brp_chk #(.BR_OPCODE(BR_OPCODE), .CNT_W(CNT_W)) u_brp_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_i         (mode_i),
    .in_valid_i     (in_valid_i),
    .in_insn_i      (in_insn_i),
    .out_valid_o    (out_valid_o),
    .is_branch_o    (is_branch_o),
    .pred_taken_o   (pred_taken_o),
    .redirect_o     (redirect_o),
    .bubble_o       (bubble_o),
    .bwd_pred_cnt_o (bwd_pred_cnt_o),
    .bwd_hit_cnt_o  (bwd_hit_cnt_o),
    .fwd_pred_cnt_o (fwd_pred_cnt_o),
    .fwd_hit_cnt_o  (fwd_hit_cnt_o)
);

// File: tb/brp_static_top_bench.sv
`timescale 1ns/1ps
module brp_static_top_bench;
    localparam int BUB   = 2;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        iv = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] pc = '0;
    logic        rv = 1'b0;
    logic        rt = 1'b0;

    logic        ov, isbr, ptk, redir, bub;
    logic [31:0] tgt;
    logic [15:0] bp, bh, fp, fh;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    brp_static_top #(.BUBBLES(BUB), .TRACK_DEPTH(DEPTH)) u_brp_static_top (
        .clk(clk), .rst(rst), .mode_i(mode), .in_valid_i(iv), .in_insn_i(insn),
        .in_pc_i(pc), .resolve_valid_i(rv), .resolve_taken_i(rt),
        .out_valid_o(ov), .is_branch_o(isbr), .pred_taken_o(ptk), .target_o(tgt),
        .redirect_o(redir), .bubble_o(bub),
        .bwd_pred_cnt_o(bp), .bwd_hit_cnt_o(bh), .fwd_pred_cnt_o(fp), .fwd_hit_cnt_o(fh)
    );

    // reference model
    bit       e_ov, e_isbr, e_tk, e_redir;
    bit [31:0] e_tgt;
    int       e_bub = 0;
    int       c_bp = 0, c_bh = 0, c_fp = 0, c_fh = 0;
    bit [1:0] q[$];
    bit [1:0] mode_seen;

    function automatic int sat(int v);
        return (v >= 65535) ? 65535 : v + 1;
    endfunction

    always @(posedge clk) begin
        bit br, bwd, tk;
        bit [1:0] e;
        if (rst) begin
            e_ov = 0; e_isbr = 0; e_tk = 0; e_redir = 0; e_tgt = '0; e_bub = 0;
            c_bp = 0; c_bh = 0; c_fp = 0; c_fh = 0;
            q.delete();
        end else begin
            br  = iv && (insn[31:26] == 6'b000100);
            bwd = insn[15];
            tk  = br && (mode == 2'b01 || (mode[1] && bwd));
            mode_seen = mode;
            e_ov = iv; e_isbr = br; e_tk = tk; e_redir = tk;
            if (iv) e_tgt = pc + {{14{insn[15]}}, insn[15:0], 2'b00};
            if (tk) e_bub = BUB;
            else if (e_bub > 0) e_bub = e_bub - 1;
            if (rv && q.size() > 0) begin
                e = q.pop_front();
                if (e[1]) begin
                    c_bp = sat(c_bp);
                    if (e[0] == rt) c_bh = sat(c_bh);
                end else begin
                    c_fp = sat(c_fp);
                    if (e[0] == rt) c_fh = sat(c_fh);
                end
            end
            if (br && q.size() < DEPTH) q.push_back({bwd, tk});
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            chk("R2 out_valid", {31'b0, ov}, {31'b0, e_ov});
            chk("R2/R7 is_branch", {31'b0, isbr}, {31'b0, e_isbr});
            chk(mode_seen == 2'b00 ? "R4 pred_taken" :
                mode_seen == 2'b01 ? "R5 pred_taken" : "R6 pred_taken",
                {31'b0, ptk}, {31'b0, e_tk});
            chk("R8 redirect", {31'b0, redir}, {31'b0, e_redir});
            chk("R8 bubble", {31'b0, bub}, {31'b0, (e_bub > 0)});
            if (e_isbr) chk("R3 target", tgt, e_tgt);
            chk("R9 bwd_pred", {16'b0, bp}, c_bp);
            chk("R9 bwd_hit",  {16'b0, bh}, c_bh);
            chk("R9 fwd_pred", {16'b0, fp}, c_fp);
            chk("R9 fwd_hit",  {16'b0, fh}, c_fh);
        end
    end

    function automatic logic [31:0] br_w(logic [15:0] d);
        return {6'b000100, 10'h155, d};
    endfunction

    task automatic step(bit v, logic [31:0] w, logic [31:0] p, bit r_v, bit r_t);
        @(negedge clk);
        #1;
        iv = v; insn = w; pc = p; rv = r_v; rt = r_t;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0);
    endtask

    initial begin : watchdog
        while (cycles < 190000 && !done) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R1: outputs after reset
        chk("R1 reset outputs", {26'b0, ov, isbr, ptk, redir, bub, |tgt}, 32'h0);
        chk("R1 reset counters", {bp | bh, fp | fh}, 32'h0);

        // R6 backward-taken policy
        mode = 2'b10;
        step(1, br_w(16'hFFF8), 32'h0000_1000, 0, 0);   // backward -> taken
        step(1, br_w(16'h0010), 32'h0000_2000, 0, 0);   // forward -> not taken
        step(1, br_w(16'h0000), 32'h0000_3000, 0, 0);   // zero -> not taken
        step(1, 32'h8C00_FFF0, 32'h0000_4000, 0, 0);    // R7 non-branch
        step(0, br_w(16'hFFF0), 32'h0000_5000, 0, 0);   // R7 invalid
        step(1, br_w(16'hFFFC), 32'h0000_0004, 0, 0);   // R3 wrap below zero
        idle(3);
        // resolve the four recorded
        step(0, '0, '0, 1, 1);
        step(0, '0, '0, 1, 1);
        step(0, '0, '0, 1, 0);
        step(0, '0, '0, 1, 1);
        idle(2);

        // R4 never-taken
        mode = 2'b00;
        step(1, br_w(16'h8000), 32'h1234_5678, 0, 0);
        step(1, br_w(16'h7FFF), 32'hFFFF_FFF0, 1, 0);
        step(1, br_w(16'hFFFF), 32'h0000_0100, 1, 1);
        idle(2);

        // R5 always-taken, back-to-back redirects restart the bubble (R8)
        mode = 2'b01;
        step(1, br_w(16'h0040), 32'h0000_8000, 1, 1);
        step(1, br_w(16'hFF00), 32'h0000_8004, 0, 0);
        step(0, '0, '0, 0, 0);
        step(1, 32'h0000_0000, 32'h0000_8010, 0, 0);    // non-branch
        step(1, br_w(16'h0001), 32'h0000_8014, 0, 0);
        idle(4);

        // R6 alternate encoding 2'b11
        mode = 2'b11;
        step(1, br_w(16'h8001), 32'h0001_0000, 0, 0);
        step(1, br_w(16'h7000), 32'h0001_0004, 0, 0);
        // overrun the tracker: six more branches, no resolves (R9 drop)
        for (int i = 0; i < 6; i++)
            step(1, br_w(i[0] ? 16'hFFE0 : 16'h0020), 32'h0002_0000 + 32'(i * 4), 0, 0);
        idle(1);
        for (int i = 0; i < 6; i++) step(0, '0, '0, 1, i[1]);
        idle(2);

        // R11: resolves with nothing outstanding
        begin
            logic [15:0] s_bp, s_bh, s_fp, s_fh;
            s_bp = bp; s_bh = bh; s_fp = fp; s_fh = fh;
            step(0, '0, '0, 1, 1);
            step(0, '0, '0, 1, 0);
            idle(1);
            @(negedge clk); #2;
            chk("R11 empty resolve bwd", {bp, bh}, {s_bp, s_bh});
            chk("R11 empty resolve fwd", {fp, fh}, {s_fp, s_fh});
        end

        // R10: saturate forward counters
        mode = 2'b00;
        step(1, br_w(16'h0008), 32'h0003_0000, 0, 0);
        for (int i = 0; i < 65540; i++) step(1, br_w(16'h0008), 32'h0003_0000, 1, 0);
        step(0, '0, '0, 1, 0);
        idle(2);
        @(negedge clk); #2;
        chk("R10 fwd_pred saturated", {16'b0, fp}, 32'h0000_FFFF);
        chk("R10 fwd_hit saturated", {16'b0, fh}, 32'h0000_FFFF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule